// File: doc/BRIEF.md
# Sampled-Channel Serial Converter Device Model

This block is the device side of a multi-channel serial converter with four general-purpose pins, written as synthesizable RTL so that a master controller can be checked in simulation against a device that behaves like the real one. It takes 16-bit command words over a mode-0 serial link, with a chip select and a serial clock that are oversampled by the system clock. From those words it keeps a settings register and a pin-direction register. It answers with 16-bit response words. The analog front end is replaced by a flat bus that holds one sample per channel.

Conversion follows the converter's pipeline. The channel named in a frame is sampled when that frame ends. The result moves through one internal stage during the next frame and is shifted out in the frame after that. A command field can also turn on pin readback: the top nibble of the response then carries the four pin levels in place of the channel number. Settings change only when a command carries its write-enable bit.

Top module: `adc_dev_model`

## Requirements
- R1: A command whose bits 15:12 are 0001 selects the channel in bits 10:7. Its response carries that channel in bits 15:12 and the channel's sample, left-aligned, in bits 11:0.
- R2: The response to the command committed in frame N is shifted out during frame N+2. The first two full frames after reset return 0x0000.
- R3: A 0001 command stores its bits 6:0 into the settings register only when bit 11 is 1. Otherwise the settings are unchanged. Settings bits 3:0 drive gpioOut, bit 5 drives powerDown and bit 6 drives rangeHigh.
- R4: A command whose bits 15:12 are 0100 and whose bit 9 is 0 loads its bits 3:0 as the pin directions (1 = output), visible on gpioOe.
- R5: A 0100 command with bit 9 set clears both the settings and the pin directions. The channel that is sampled next is the last one selected.
- R6: When settings bit 4 is 1 after a command has been applied, the sample taken for that command reports pin levels in response bits 15:12. Output pins report their driven level and input pins report gpioIn.
- R7: Any other value of bits 15:12, including 0000, changes no register and samples the last selected channel again.
- R8: A frame in which chip select rises after any number of rising serial clock edges other than 16 is ignored. No register changes and the pipeline does not advance.
- R9: After reset gpioOut, gpioOe, powerDown and rangeHigh are 0. miso is 0 whenever chip select is high.
- R10: mosi is taken MSB first on rising serial clock edges. The first response bit is on miso after chip select falls, and miso advances after each falling serial clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select, frames a 16-bit word |
| sclk | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Command data from the master |
| miso | output | 1 | Response data to the master |
| gpioIn | input | 4 | External levels of the four pins |
| sampleBus | input | NUM_CH*SAMPLE_W | Per-channel sample values, channel 0 in the low bits |
| gpioOut | output | 4 | Driven level of each pin |
| gpioOe | output | 4 | Pin direction, 1 = output |
| powerDown | output | 1 | Power-down setting |
| rangeHigh | output | 1 | Doubled input range setting |

## Verification
The frames sent select several distinct channels, with and without the write-enable bit, so a response that shows the wrong channel, a wrong sample or a wrong pipeline offset differs from the expected word. Pin configuration and pin-reset commands, and the continue and unused opcodes, are sent between the selecting commands. This shows that those commands resample the last channel and do not disturb the settings. The readback frame mixes output and input pins at differing levels, so a swap of driven and external levels becomes visible. A truncated frame carrying a write is followed by full frames, and their responses and port levels show whether it leaked into the settings or advanced the pipeline.

// File: rtl/adc_dev_pkg.sv
`timescale 1ns/1ps
package adc_dev_pkg;
  localparam int FRAME_W = 16;
  localparam int DATA_W  = 12;
  localparam int PIN_N   = 4;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  localparam logic [3:0] OP_MANUAL = 4'b0001;
  localparam logic [3:0] OP_PINCFG = 4'b0100;

  typedef struct packed {
    logic loadTx;
    logic shiftIn;
    logic shiftOut;
    logic commit;
  } frame_strobe_t;
endpackage

// File: rtl/adc_dev_ctrl.sv
`timescale 1ns/1ps
module adc_dev_ctrl
  import adc_dev_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          sclk,
  output frame_strobe_t strobe
);
  localparam logic [CNT_W-1:0] CNT_CAP  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic prevCs;
  logic prevSclk;
  logic [CNT_W-1:0] bitCnt;
  logic csFall, csRise, sclkRise, sclkFall;

  assign csFall   = prevCs & ~csN;
  assign csRise   = ~prevCs & csN;
  assign sclkRise = sclk & ~prevSclk;
  assign sclkFall = ~sclk & prevSclk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCs   <= 1'b1;
      prevSclk <= 1'b0;
      bitCnt   <= '0;
    end else begin
      prevCs   <= csN;
      prevSclk <= sclk;
      if (csFall)
        bitCnt <= '0;
      else if (sclkRise && !csN && bitCnt != CNT_CAP)
        bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.loadTx   = csFall;
    strobe.shiftIn  = ~csN & sclkRise;
    strobe.shiftOut = ~csN & sclkFall;
    strobe.commit   = csRise & (bitCnt == CNT_FULL);
  end

  AST_CNT_CAPPED: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_CAP); // R8
  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |=> bitCnt == '0); // R10
endmodule

// File: rtl/adc_dev_datapath.sv
`timescale 1ns/1ps
module adc_dev_datapath
  import adc_dev_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int SAMPLE_W = 12
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  frame_strobe_t                strobe,
  input  logic                         mosi,
  input  logic [PIN_N-1:0]             gpioIn,
  input  logic [NUM_CH*SAMPLE_W-1:0]   sampleBus,
  output logic                         txMsb,
  output logic [PIN_N-1:0]             gpioOut,
  output logic [PIN_N-1:0]             gpioOe,
  output logic                         powerDown,
  output logic                         rangeHigh
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [FRAME_W-1:0] rxShift, txShift, txWord, stageWord, newWord;
  logic [6:0]         settings, nextSettings;
  logic [PIN_N-1:0]   dirReg, nextDir, pinLevel;
  logic [3:0]         curChan, nextChan;
  logic [3:0]         opcode;
  logic               isManual, isPinCfg;
  logic [SAMPLE_W-1:0] chanArr [NUM_CH];
  logic [SAMPLE_W-1:0] rawSample;
  logic [DATA_W-1:0]   alignedSample;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_unpack
    assign chanArr[ch] = sampleBus[ch*SAMPLE_W +: SAMPLE_W];
  end

  if (NUM_CH < 16) begin : g_partial
    assign rawSample = (nextChan < 4'(NUM_CH)) ? chanArr[nextChan[IDX_W-1:0]] : '0;
  end else begin : g_full
    assign rawSample = chanArr[nextChan[IDX_W-1:0]];
  end

  if (SAMPLE_W < DATA_W) begin : g_pad
    assign alignedSample = {rawSample, {(DATA_W-SAMPLE_W){1'b0}}};
  end else begin : g_exact
    assign alignedSample = rawSample;
  end

  assign opcode   = rxShift[15:12];
  assign isManual = (opcode == OP_MANUAL);
  assign isPinCfg = (opcode == OP_PINCFG);

  always_comb begin
    nextSettings = settings;
    nextDir      = dirReg;
    nextChan     = curChan;
    if (isManual) begin
      nextChan = rxShift[10:7];
      if (rxShift[11]) nextSettings = rxShift[6:0];
    end else if (isPinCfg) begin
      if (rxShift[9]) begin
        nextSettings = '0;
        nextDir      = '0;
      end else begin
        nextDir = rxShift[3:0];
      end
    end
    pinLevel = (nextDir & nextSettings[3:0]) | (~nextDir & gpioIn);
    newWord  = nextSettings[4] ? {pinLevel, alignedSample} : {nextChan, alignedSample};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift   <= '0;
      txShift   <= '0;
      txWord    <= '0;
      stageWord <= '0;
      settings  <= '0;
      dirReg    <= '0;
      curChan   <= '0;
    end else begin
      if (strobe.shiftIn)
        rxShift <= {rxShift[FRAME_W-2:0], mosi};
      if (strobe.loadTx)
        txShift <= txWord;
      else if (strobe.shiftOut)
        txShift <= {txShift[FRAME_W-2:0], 1'b0};
      if (strobe.commit) begin
        txWord    <= stageWord;
        stageWord <= newWord;
        settings  <= nextSettings;
        dirReg    <= nextDir;
        curChan   <= nextChan;
      end
    end
  end

  assign txMsb     = txShift[FRAME_W-1];
  assign gpioOut   = settings[3:0];
  assign gpioOe    = dirReg;
  assign powerDown = settings[5];
  assign rangeHigh = settings[6];

  AST_SETTINGS_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && rxShift[15:12] == OP_MANUAL && !rxShift[11]) |=> $stable(settings)); // R3
  AST_SETTINGS_WRITTEN: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && rxShift[15:12] == OP_MANUAL && rxShift[11]) |=> settings == $past(rxShift[6:0])); // R3
  AST_DIR_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && rxShift[15:12] == OP_PINCFG && !rxShift[9]) |=> gpioOe == $past(rxShift[3:0])); // R4
  AST_REGS_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && rxShift[15:12] == OP_PINCFG && rxShift[9]) |=> (settings == '0 && gpioOe == '0)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> ($stable(txWord) && $stable(stageWord) && $stable(settings))); // R8
  AST_OTHER_OP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !isManual && !isPinCfg) |=> ($stable(settings) && $stable(gpioOe))); // R7
endmodule

// File: rtl/adc_dev_model.sv
`timescale 1ns/1ps
module adc_dev_model
  import adc_dev_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int SAMPLE_W = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       csN,
  input  logic                       sclk,
  input  logic                       mosi,
  output logic                       miso,
  input  logic [3:0]                 gpioIn,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleBus,
  output logic [3:0]                 gpioOut,
  output logic [3:0]                 gpioOe,
  output logic                       powerDown,
  output logic                       rangeHigh
);
  frame_strobe_t strobe;
  logic          txMsb;

  adc_dev_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .sclk   (sclk),
    .strobe (strobe)
  );

  adc_dev_datapath #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .mosi      (mosi),
    .gpioIn    (gpioIn),
    .sampleBus (sampleBus),
    .txMsb     (txMsb),
    .gpioOut   (gpioOut),
    .gpioOe    (gpioOe),
    .powerDown (powerDown),
    .rangeHigh (rangeHigh)
  );

  assign miso = ~csN & txMsb;
endmodule

// File: tb/test_adc_dev_model.sv
`timescale 1ns/1ps
module test_adc_dev_model;
  localparam int NUM_CH   = 16;
  localparam int SAMPLE_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic miso;
  logic [3:0] gpioIn = 4'b0000;
  logic [NUM_CH*SAMPLE_W-1:0] sampleBus;
  logic [3:0] gpioOut, gpioOe;
  logic powerDown, rangeHigh;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] expQ[$];
  string       tagQ[$];

  // bench model state
  logic [15:0] mTx = '0, mStage = '0;
  logic [6:0]  mSet = '0;
  logic [3:0]  mDir = '0, mChan = '0;

  always #2.5 clk = ~clk;

  adc_dev_model #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) i_adc_dev_model (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi), .miso(miso),
    .gpioIn(gpioIn), .sampleBus(sampleBus), .gpioOut(gpioOut), .gpioOe(gpioOe),
    .powerDown(powerDown), .rangeHigh(rangeHigh)
  );

  function automatic logic [11:0] sampleVal(input logic [3:0] ch);
    return 12'(32'(ch) * 32'h123 + 32'h05A);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected state update from the requirements R1, R3..R7
  task automatic modelCommit(input logic [15:0] c);
    logic [6:0] nS = mSet;
    logic [3:0] nD = mDir;
    logic [3:0] nC = mChan;
    logic [3:0] pins;
    if (c[15:12] == 4'b0001) begin
      nC = c[10:7];
      if (c[11]) nS = c[6:0];
    end else if (c[15:12] == 4'b0100) begin
      if (c[9]) begin nS = '0; nD = '0; end
      else nD = c[3:0];
    end
    pins   = (nD & nS[3:0]) | (~nD & gpioIn);
    mTx    = mStage;
    mStage = nS[4] ? {pins, sampleVal(nC)} : {nC, sampleVal(nC)};
    mSet = nS; mDir = nD; mChan = nC;
  endtask

  // mode-0 frame, R10: data set while sclk low, taken on the rise
  task automatic spiFrame(input logic [15:0] c, input int nBits);
    csN = 1'b0;
    waitClk(4);
    for (int i = 0; i < nBits; i++) begin
      mosi = c[15-i];
      waitClk(2);
      sclk = 1'b1;
      waitClk(4);
      sclk = 1'b0;
      waitClk(2);
    end
    waitClk(2);
    csN = 1'b1;
    waitClk(4);
  endtask

  task automatic sendCmd(input logic [15:0] c, input string tag);
    expQ.push_back(mTx);
    tagQ.push_back(tag);
    spiFrame(c, 16);
    modelCommit(c);
  endtask

  // monitor: assembles miso on rising sclk and scores at chip-select rise
  logic [15:0] monWord = '0;
  int          monBits = 0;
  always @(negedge csN) begin
    monBits = 0;
    monWord = '0;
  end
  always @(posedge sclk) begin
    if (!csN) begin
      monWord = {monWord[14:0], miso};
      monBits++;
    end
  end
  always @(posedge csN) begin
    if (monBits == 16) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 actual=%h expected=none", monWord);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, monWord, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int ch = 0; ch < NUM_CH; ch++)
      sampleBus[ch*SAMPLE_W +: SAMPLE_W] = sampleVal(4'(ch));
    waitClk(4);
    rstN = 1'b1;
    waitClk(2);
    // R9 reset state
    check("R9 reset pins", {8'h00, gpioOut, gpioOe}, 16'h0000);
    check("R9 reset flags", {14'h0, powerDown, rangeHigh}, 16'h0000);
    check("R9 miso idle", {15'h0, miso}, 16'h0000);

    sendCmd(16'h1000 | (16'd3 << 7), "R2 first frame");                 // F1 ch3
    sendCmd(16'h1000 | (16'd7 << 7) | 16'h0800 | 16'h0045, "R2 second frame"); // F2 ch7 write
    check("R3 gpioOut written", {12'h0, gpioOut}, 16'h0005);
    check("R3 rangeHigh written", {15'h0, rangeHigh}, 16'h0001);
    sendCmd(16'h1000 | (16'd12 << 7), "R1 ch3 response");                // F3 ch12 no write
    check("R3 settings kept", {12'h0, gpioOut}, 16'h0005);
    sendCmd(16'h4003, "R1 ch7 response");                                 // F4 pin config
    check("R4 directions", {12'h0, gpioOe}, 16'h0003);
    sendCmd(16'h0000, "R1 ch12 response R10");                           // F5 continue
    check("R7 continue keeps pins", {8'h0, gpioOut, gpioOe}, 16'h0053);
    gpioIn = 4'b0110;
    sendCmd(16'h1000 | (16'd5 << 7) | 16'h0800 | 16'h005A, "R7 pincfg resample"); // F6 readback on
    check("R3 settings 5A", {12'h0, gpioOut}, 16'h000A);
    // R8 truncated frame carrying a write
    spiFrame(16'h1800 | 16'h007F, 8);
    check("R8 truncated ignored", {12'h0, gpioOut}, 16'h000A);
    check("R8 truncated power", {15'h0, powerDown}, 16'h0000);
    check("R9 miso idle between", {15'h0, miso}, 16'h0000);
    sendCmd(16'h1000 | (16'd9 << 7) | 16'h0800, "R7 continue resample R8");      // F8
    sendCmd(16'h2000, "R6 readback levels");                              // F9 unused opcode
    sendCmd(16'h4200, "R6 readback cleared");                             // F10 pin reset
    check("R5 reset pins", {8'h0, gpioOut, gpioOe}, 16'h0000);
    check("R5 reset range", {15'h0, rangeHigh}, 16'h0000);
    sendCmd(16'h1000 | (16'd15 << 7) | 16'h0800 | 16'h0020, "R7 unused opcode resample"); // F11
    check("R3 powerDown", {15'h0, powerDown}, 16'h0001);
    sendCmd(16'h0000, "R5 resample after reset");
    sendCmd(16'h0000, "R1 ch15 response");
    check("R2 queue drained", 16'(expQ.size()), 16'h0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule